// File: doc/BRIEF.md
# Add / Move-Not Execute Stage with Status Flags

This block is the arithmetic back end of an execute stage. It handles two data-processing operations. The first is an addition of a first operand and an already-shifted second operand. The second is a move-not, which writes the bitwise inverse of the shifted second operand. The operand values, the carry produced by the upstream shifter, the operation select, a flag-update request, the destination register index and the saved status word all arrive in the same cycle. The block returns the result and a write strobe for the destination register straight away, in the same cycle.

The block owns the current status word, which is a clocked register. The four condition flags sit in the top four bits: negative at bit 31, zero at 30, carry at 29 and overflow at 28. When flag update is requested, the flags are recomputed from the operation and the other 28 bits are kept. When flag update is requested and the destination is the program-counter index (15), the whole status word is reloaded from the saved status input instead. The shifter and the register file lie outside the block.

Top module: `addmv_exec`

## Requirements
- R1: With `op_sel`=0 (add), `result` equals `opa + opb` modulo 2^32.
- R2: With `op_sel`=1 (move-not), `result` equals the bitwise inverse of `opb`, and `opa` has no effect on it.
- R3: On a flag-updating operation whose destination is not 15, bit 31 of `status` (N) takes `result[31]` and bit 30 (Z) is set exactly when all 32 result bits are zero.
- R4: On a flag-updating add, bit 29 (C) is set exactly when the 32-bit sum is unsigned-less than `opa`, that is, when the addition carries out.
- R5: On a flag-updating add, bit 28 (V) is set exactly when both operands have the same sign and the result sign differs from it.
- R6: On a flag-updating move-not, C takes `shift_carry` and V keeps its previous value.
- R7: When `set_flags`=1 and `dst_idx`=15 on an issued operation, `status` is loaded with `saved_status` on the next clock edge and no flags are computed.
- R8: When `set_flags`=0, `status` is unchanged. A flag update changes only bits 31 to 28 and keeps bits 27 to 0.
- R9: `rd_wr_en` is high for every issued operation (`issue`=1), whatever `set_flags` is, and low otherwise.
- R10: After reset, `status` reads all zero.
- R11: With `issue`=0, `status` is unchanged, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| issue | input | 1 | An operation is presented this cycle |
| op_sel | input | 1 | 0 = add, 1 = move-not |
| set_flags | input | 1 | Request a status update |
| dst_idx | input | 4 | Destination register index |
| opa | input | 32 | First operand |
| opb | input | 32 | Shifted second operand |
| shift_carry | input | 1 | Carry out of the upstream shifter |
| saved_status | input | 32 | Saved status word |
| result | output | 32 | Operation result |
| rd_wr_en | output | 1 | Destination register write strobe |
| status_nxt | output | 32 | Status word to be loaded on the next edge |
| status | output | 32 | Current status word |

## Verification
On every cycle the assertions check the register-side behaviour. They cover the hold when no update is requested, the reload from the saved word on a write to index 15, the zero flag against the visible result, the add carry against the operands, the move-not carry and overflow rules, and that the low 28 bits are kept. Only the bench scenarios can show the actual arithmetic values. These are wrap-around sums, signed overflow at both sign extremes, a move-not that ignores its first operand, and the write strobe on non-flag operations. The bench also covers long mixed sequences, where each flag depends on the history of earlier updates.

// File: rtl/addmv_pkg.sv
package addmv_pkg;
  typedef enum logic {
    OPC_ADD = 1'b0,
    OPC_MVN = 1'b1
  } opc_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;
endpackage

// File: rtl/addmv_rst_sync.sv
module addmv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/addmv_core.sv
module addmv_core
  import addmv_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  opc_e          opc,
  output logic [DW-1:0] res,
  output logic          add_carry,
  output logic          add_ovf
);
  logic [DW:0]   sum_wide;
  logic [DW-1:0] ovf_vec;

  always_comb begin
    sum_wide  = {1'b0, opa} + {1'b0, opb};
    ovf_vec   = ~(opa ^ opb) & (opa ^ sum_wide[DW-1:0]);
    add_carry = sum_wide[DW];
    add_ovf   = ovf_vec[DW-1];
    if (opc == OPC_MVN) res = ~opb;
    else                res = sum_wide[DW-1:0];
  end
endmodule

// File: rtl/addmv_flags.sv
module addmv_flags
  import addmv_pkg::*;
#(
  parameter int DW     = 32,
  parameter int AW     = 4,
  parameter int PC_IDX = 15
) (
  input  logic          issue,
  input  logic          set_flags,
  input  logic [AW-1:0] dst_idx,
  input  opc_e          opc,
  input  logic [DW-1:0] res,
  input  logic          add_carry,
  input  logic          add_ovf,
  input  logic          shift_carry,
  input  logic [DW-1:0] cur_sr,
  input  logic [DW-1:0] saved_sr,
  output logic [DW-1:0] nxt_sr
);
  localparam int FLAG_LO = DW - 4;
  localparam logic [AW-1:0] PC_SEL = AW'(PC_IDX);

  nzcv_t old_f, new_f;

  always_comb begin
    old_f   = cur_sr[DW-1:FLAG_LO];
    new_f.n = res[DW-1];
    new_f.z = (res == '0);
    if (opc == OPC_MVN) begin
      new_f.c = shift_carry;
      new_f.v = old_f.v;
    end else begin
      new_f.c = add_carry;
      new_f.v = add_ovf;
    end

    nxt_sr = cur_sr;
    if (issue && set_flags) begin
      if (dst_idx == PC_SEL) nxt_sr = saved_sr;
      else                   nxt_sr = {new_f, cur_sr[FLAG_LO-1:0]};
    end
  end
endmodule

// File: rtl/addmv_exec.sv
module addmv_exec
  import addmv_pkg::*;
#(
  parameter int DW     = 32,
  parameter int AW     = 4,
  parameter int PC_IDX = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic          op_sel,
  input  logic          set_flags,
  input  logic [AW-1:0] dst_idx,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic          shift_carry,
  input  logic [DW-1:0] saved_status,
  output logic [DW-1:0] result,
  output logic          rd_wr_en,
  output logic [DW-1:0] status_nxt,
  output logic [DW-1:0] status
);
  logic          srst_n;
  logic          a_carry, a_ovf;
  logic          sr_en;
  logic [DW-1:0] sr_q;
  opc_e          opc;

  assign opc = opc_e'(op_sel);

  addmv_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  addmv_core #(.DW(DW)) u_core (
    .opa       (opa),
    .opb       (opb),
    .opc       (opc),
    .res       (result),
    .add_carry (a_carry),
    .add_ovf   (a_ovf)
  );

  addmv_flags #(.DW(DW), .AW(AW), .PC_IDX(PC_IDX)) u_flags (
    .issue       (issue),
    .set_flags   (set_flags),
    .dst_idx     (dst_idx),
    .opc         (opc),
    .res         (result),
    .add_carry   (a_carry),
    .add_ovf     (a_ovf),
    .shift_carry (shift_carry),
    .cur_sr      (sr_q),
    .saved_sr    (saved_status),
    .nxt_sr      (status_nxt)
  );

  assign sr_en    = issue & set_flags;
  assign rd_wr_en = issue;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)    sr_q <= '0;
    else if (sr_en) sr_q <= status_nxt;
  end

  assign status = sr_q;
endmodule

// File: rtl/addmv_exec_chk.sv
module addmv_exec_chk #(
  parameter int DW     = 32,
  parameter int AW     = 4,
  parameter int PC_IDX = 15
) (
  input logic          clk,
  input logic          srst_n,
  input logic          issue,
  input logic          op_sel,
  input logic          set_flags,
  input logic [AW-1:0] dst_idx,
  input logic [DW-1:0] opa,
  input logic          shift_carry,
  input logic [DW-1:0] saved_status,
  input logic [DW-1:0] result,
  input logic [DW-1:0] status
);
  logic upd;
  assign upd = issue && set_flags && (dst_idx != AW'(PC_IDX));

  AST_HOLD_NO_UPDATE: assert property (@(posedge clk) disable iff (!srst_n)
    !(issue && set_flags) |=> $stable(status)); // R8

  AST_PC_RESTORE: assert property (@(posedge clk) disable iff (!srst_n)
    (issue && set_flags && dst_idx == AW'(PC_IDX)) |=> status == $past(saved_status)); // R7

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!srst_n)
    upd |=> status[DW-2] == ($past(result) == '0)); // R3

  AST_ADD_CARRY: assert property (@(posedge clk) disable iff (!srst_n)
    (upd && !op_sel) |=> status[DW-3] == ($past(result) < $past(opa))); // R4

  AST_MVN_CARRY: assert property (@(posedge clk) disable iff (!srst_n)
    (upd && op_sel) |=> status[DW-3] == $past(shift_carry)); // R6

  AST_MVN_KEEP_V: assert property (@(posedge clk) disable iff (!srst_n)
    (upd && op_sel) |=> status[DW-4] == $past(status[DW-4])); // R6

  AST_LOW_BITS_KEPT: assert property (@(posedge clk) disable iff (!srst_n)
    upd |=> status[DW-5:0] == $past(status[DW-5:0])); // R8
endmodule

bind addmv_exec addmv_exec_chk #(.DW(DW), .AW(AW), .PC_IDX(PC_IDX)) u_chk (
  .clk          (clk),
  .srst_n       (srst_n),
  .issue        (issue),
  .op_sel       (op_sel),
  .set_flags    (set_flags),
  .dst_idx      (dst_idx),
  .opa          (opa),
  .shift_carry  (shift_carry),
  .saved_status (saved_status),
  .result       (result),
  .status       (status)
);

// File: tb/test_addmv_exec.sv
module test_addmv_exec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic        op_sel = 1'b0;
  logic        set_flags = 1'b0;
  logic [3:0]  dst_idx = '0;
  logic [31:0] opa = '0, opb = '0, saved_status = '0;
  logic        shift_carry = 1'b0;
  logic [31:0] result, status_nxt, status;
  logic        rd_wr_en;

  int total = 0;
  int bad = 0;
  logic [31:0] model_sr = '0;
  logic drv_done = 1'b0;

  typedef struct {
    logic        chk_res;
    logic [31:0] res;
    logic        we;
    logic [31:0] sr;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  addmv_exec i_addmv_exec (
    .clk(clk), .rst_n(rst_n), .issue(issue), .op_sel(op_sel),
    .set_flags(set_flags), .dst_idx(dst_idx), .opa(opa), .opb(opb),
    .shift_carry(shift_carry), .saved_status(saved_status),
    .result(result), .rd_wr_en(rd_wr_en), .status_nxt(status_nxt),
    .status(status)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic mv, input logic s, input logic [3:0] d,
                       input logic [31:0] a, input logic [31:0] b, input logic sc,
                       input logic [31:0] sv, input string tag);
    exp_t e;
    logic [32:0] w;
    logic [31:0] r;
    logic n, z, c, ov;
    @(negedge clk);
    issue = v; op_sel = mv; set_flags = s; dst_idx = d;
    opa = a; opb = b; shift_carry = sc; saved_status = sv;
    w = {1'b0, a} + {1'b0, b};
    r = mv ? ~b : w[31:0];
    n = r[31]; z = (r == 32'd0);
    if (mv) begin c = sc; ov = model_sr[28]; end
    else begin c = w[32]; ov = (a[31] == b[31]) && (r[31] != a[31]); end
    if (v && s) begin
      if (d == 4'd15) model_sr = sv;
      else            model_sr = {n, z, c, ov, model_sr[27:0]};
    end
    e.chk_res = v; e.res = r; e.we = v; e.sr = model_sr; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: outputs settle between edges, the status register after the edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        if (e.chk_res) check(result === e.res, {e.tag, " result"}, result, e.res);
        check(rd_wr_en === e.we, {e.tag, " R9 wr_en"}, {31'd0, rd_wr_en}, {31'd0, e.we});
        check(status === e.sr, {e.tag, " status"}, status, e.sr);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(status === 32'd0, "R10 reset status", status, 32'd0);

    drive(1, 0, 0, 4'd2, 32'd5, 32'd7, 0, 32'h0, "R1 R8 plain add");
    drive(1, 0, 1, 4'd3, 32'hFFFF_FFFF, 32'd1, 0, 32'h0, "R3 R4 wrap to zero");
    drive(1, 0, 1, 4'd3, 32'h7FFF_FFFF, 32'd1, 0, 32'h0, "R5 positive overflow");
    drive(1, 0, 1, 4'd3, 32'h8000_0000, 32'h8000_0000, 0, 32'h0, "R4 R5 negative overflow");
    drive(1, 1, 1, 4'd4, 32'h1234_5678, 32'hFFFF_FFFF, 1, 32'h0, "R2 R6 mvn zero keep V");
    drive(1, 0, 1, 4'd15, 32'd1, 32'd1, 0, 32'h0000_00D3, "R7 restore saved");
    drive(1, 0, 1, 4'd1, 32'd1, 32'd2, 0, 32'hFFFF_FFFF, "R8 low bits kept");
    drive(1, 1, 1, 4'd1, 32'hDEAD_BEEF, 32'h0, 0, 32'h0, "R2 R3 R6 mvn negative");
    drive(0, 0, 1, 4'd15, 32'hFFFF_FFFF, 32'd1, 1, 32'hAAAA_AAAA, "R11 idle");
    drive(1, 1, 0, 4'd6, 32'h0, 32'h0F0F_0000, 1, 32'h5555_5555, "R2 R8 R9 mvn no flags");
    drive(1, 0, 1, 4'd15, 32'h0, 32'h0, 0, 32'h0000_0000, "R7 restore zero");

    lf = 32'hACE1_1234;
    for (int i = 0; i < 200; i++) begin
      logic [31:0] a, b;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]}; a = lf;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]}; b = lf;
      drive(a[3] | a[9], b[4], b[7] | b[1], b[15:12], a, (b[2] ? b : ~a + 32'd1),
            a[20], {a[15:0], b[15:0]}, "R1 R3 R4 R5 R6 R7 mixed");
    end

    drv_done = 1'b1;
    @(negedge clk);
    issue = 1'b0;
    while (sb_q.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule